// File: doc/BRIEF.md
# Keyed-Transmit Sequencer with Tone-Inhibit Lead

This block sits between a station identifier, the squelch output of a link receiver and the accessory connector of a transmitter. When the identifier asks to transmit while the link is quiet, the block raises a command line first. That line switches off the sub-audible tone or steers the channel. The block then holds the radio's active-low push-to-talk off for a settle delay. The radio only accepts a command that is already stable when keying begins: with less than 40 ms between command and key, it either ignores the command or sounds an error tone and refuses to transmit. For that reason the settle delay defaults to 50 ms and is counted in pulses of an external 1 ms tick.

If a user is talking on the link when the request arrives, the block keys at once with no command and no delay. The decision to inhibit is taken once, when the request starts, and holds for the whole transmission. This means the command line never moves while the radio is on the air, because such a change drops the carrier briefly. When the request ends, push-to-talk is released first and the command line falls at the next tick.

Both asynchronous inputs pass through two-flop synchronisers. The reset is synchronous and active low.

Top module: `ptt_sequencer`

## Requirements
- R1: During and after reset, `ptt_n_o` is 1 and `inhibit_o` is 0.
- R2: A request with COR inactive raises `inhibit_o` on the third rising clock edge after the request changes, and `ptt_n_o` stays 1 at that point.
- R3: Once `inhibit_o` has risen, `ptt_n_o` falls only after exactly `SETTLE_MS` tick pulses (1 = one pulse) have been sampled while `inhibit_o` was high. `inhibit_o` is still 1 when `ptt_n_o` falls.
- R4: A request with COR active (`cor_i` = 1) pulls `ptt_n_o` low on the third rising edge after the request changes, and `inhibit_o` stays 0 for the whole transmission.
- R5: A change of `cor_i` after the request has started alters neither `inhibit_o` nor the settle timing.
- R6: When the request ends during an inhibited transmission, `ptt_n_o` returns to 1 while `inhibit_o` stays 1. `inhibit_o` then falls on the first clock edge that samples a tick pulse.
- R7: If the request ends during the settle delay, `inhibit_o` falls on the third edge and `ptt_n_o` never goes low. The next request again waits the full `SETTLE_MS` ticks.
- R8: A new request that arrives while the block waits to drop `inhibit_o` is not lost. The sequence restarts, and `ptt_n_o` goes low after a full settle delay with `inhibit_o` high.
- R9: While `ptt_n_o` is 0, `inhibit_o` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| id_req_i | input | 1 | Transmit request from the identifier, asynchronous, active high |
| cor_i | input | 1 | Link receiver carrier detect, asynchronous, 1 = user talking |
| ms_tick_i | input | 1 | One-clock pulse every millisecond |
| inhibit_o | output | 1 | Tone-inhibit / channel-select command to the radio, active high |
| ptt_n_o | output | 1 | Radio push-to-talk, active low |

## Verification
Two functions can meet on a single clock edge: the arrival of a fresh synchronised request and the release tick that would lower the command line. The bench provokes this by ending a transmission just after a tick, so the block sits in its release wait. It then raises the request again a few cycles later, before the next tick can come. The result passes if a complete new settle period of exactly `SETTLE_MS` ticks follows and push-to-talk then goes low with the command line high. A separate check confirms that a COR change during the settle period neither shortens the delay nor lowers the command.

// File: rtl/ptt_seq_pkg.sv
// Shared types for the keyed-transmit sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package ptt_seq_pkg;

    // Sequencer phases; the order carries no meaning.
    typedef enum logic [2:0] {
        SQ_IDLE      = 3'd0,
        SQ_SETTLE    = 3'd1,
        SQ_KEY_INH   = 3'd2,
        SQ_KEY_PLAIN = 3'd3,
        SQ_RELEASE   = 3'd4
    } seq_state_t;

    // Command line level for a phase.
    function automatic logic phase_inhibits(input seq_state_t s);
        return (s == SQ_SETTLE) || (s == SQ_KEY_INH) || (s == SQ_RELEASE);
    endfunction

    // Push-to-talk active for a phase (active high here, inverted at the pin).
    function automatic logic phase_keys(input seq_state_t s);
        return (s == SQ_KEY_INH) || (s == SQ_KEY_PLAIN);
    endfunction

endpackage

// File: rtl/ptt_sync.sv
// Multi-bit, multi-stage flop synchroniser for independent asynchronous levels.
// Assumes: each bit is a slow level; no bus coherency is needed between bits.
module ptt_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Shift each stage one step further from the asynchronous domain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= d_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ptt_settle_timer.sv
// Counts millisecond tick pulses while enabled and flags when the settle
// delay has been reached. Clears whenever the enable is low.
// Assumes: SETTLE_MS <= MAX_MS.
module ptt_settle_timer #(
    parameter int SETTLE_MS = 50,
    parameter int MAX_MS    = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic done_o
);
    localparam int CW = $clog2(MAX_MS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(SETTLE_MS);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q >= LIMIT);

    // Advance on each tick while running, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptt_seq_ctrl.sv
// Phase controller: takes the inhibit decision at request start, orders
// command-before-key on entry and key-before-command on exit, and drives
// registered, glitch-free outputs.
// Assumes: req_i and cor_i are already synchronous to clk.
module ptt_seq_ctrl
    import ptt_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic cor_i,
    input  logic tick_i,
    input  logic done_i,
    output logic run_o,
    output logic inhibit_o,
    output logic ptt_n_o
);
    seq_state_t state_q, state_d;

    // Choose the next phase from the current one and the inputs.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:      if (req_i) state_d = cor_i ? SQ_KEY_PLAIN : SQ_SETTLE;
            SQ_SETTLE:    if (!req_i) state_d = SQ_IDLE;
                          else if (done_i) state_d = SQ_KEY_INH;
            SQ_KEY_INH:   if (!req_i) state_d = SQ_RELEASE;
            SQ_KEY_PLAIN: if (!req_i) state_d = SQ_IDLE;
            SQ_RELEASE:   if (req_i || tick_i) state_d = SQ_IDLE;
            default:      state_d = SQ_IDLE;
        endcase
    end

    // Hold the phase and the pin levels it implies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            inhibit_o <= 1'b0;
            ptt_n_o   <= 1'b1;
        end else begin
            state_q   <= state_d;
            inhibit_o <= phase_inhibits(state_d);
            ptt_n_o   <= !phase_keys(state_d);
        end
    end

    assign run_o = (state_q == SQ_SETTLE);
endmodule

// File: rtl/ptt_sequencer.sv
// Top level: synchronises the request and carrier inputs, then sequences the
// tone-inhibit command ahead of push-to-talk with a tick-counted settle delay.
// Assumes: ms_tick_i is synchronous to clk and one cycle wide.
module ptt_sequencer #(
    parameter int SETTLE_MS   = 50,
    parameter int MAX_MS      = 500,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic id_req_i,
    input  logic cor_i,
    input  logic ms_tick_i,
    output logic inhibit_o,
    output logic ptt_n_o
);
    logic [1:0] raw_in, sync_in;
    logic       timer_run, timer_done;

    assign raw_in = {cor_i, id_req_i};

    ptt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (sync_in)
    );

    ptt_settle_timer #(.SETTLE_MS(SETTLE_MS), .MAX_MS(MAX_MS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (timer_run),
        .tick_i (ms_tick_i),
        .done_o (timer_done)
    );

    ptt_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (sync_in[0]),
        .cor_i     (sync_in[1]),
        .tick_i    (ms_tick_i),
        .done_i    (timer_done),
        .run_o     (timer_run),
        .inhibit_o (inhibit_o),
        .ptt_n_o   (ptt_n_o)
    );
endmodule

// File: rtl/ptt_sequencer_chk.sv
// Temporal checks on the sequencer pins, bound to every ptt_sequencer.
// Keeps its own tick count so the settle window needs no deep $past.
module ptt_sequencer_chk #(
    parameter int SETTLE_MS = 50
) (
    input logic clk,
    input logic rst_n,
    input logic ms_tick_i,
    input logic inhibit_o,
    input logic ptt_n_o
);
    logic [15:0] seen_ticks;

    // Count ticks seen while the command is up and the radio is not yet keyed.
    always_ff @(posedge clk) begin
        if (!rst_n || !inhibit_o || !ptt_n_o) begin
            seen_ticks <= '0;
        end else if (ms_tick_i && seen_ticks != 16'hFFFF) begin
            seen_ticks <= seen_ticks + 1'b1;
        end
    end

    // R9: command line frozen while keyed.
    a_r9_cmd_frozen_keyed: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptt_n_o && $past(!ptt_n_o)) |-> (inhibit_o == $past(inhibit_o)));

    // R3: an inhibited key only follows a full settle window.
    a_r3_settle_elapsed: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ptt_n_o) && inhibit_o) |-> (seen_ticks >= 16'(SETTLE_MS)));

    // R2: the command never rises while already keyed.
    a_r2_cmd_before_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(inhibit_o) |-> ptt_n_o);

    // R6: on release after an inhibited transmission the command outlives the key.
    a_r6_key_drops_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ptt_n_o) && $past(inhibit_o)) |-> inhibit_o);
endmodule

bind ptt_sequencer ptt_sequencer_chk #(.SETTLE_MS(SETTLE_MS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick_i (ms_tick_i),
    .inhibit_o (inhibit_o),
    .ptt_n_o   (ptt_n_o)
);

// File: tb/ptt_sequencer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module ptt_sequencer_bench;
    localparam int SETTLE_MS = 50;
    localparam int TICK_DIV  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_req_i = 1'b0;
    logic cor_i = 1'b0;
    logic ms_tick_i = 1'b0;
    logic inhibit_o, ptt_n_o;

    int checks = 0;
    int errors = 0;
    int div_cnt = 0;

    ptt_sequencer #(.SETTLE_MS(SETTLE_MS)) u_ptt_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_req_i  (id_req_i),
        .cor_i     (cor_i),
        .ms_tick_i (ms_tick_i),
        .inhibit_o (inhibit_o),
        .ptt_n_o   (ptt_n_o)
    );

    always #10 clk = ~clk;

    // Millisecond tick stand-in: one-cycle pulse every TICK_DIV clocks.
    always @(posedge clk) begin
        div_cnt   <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
        ms_tick_i <= (div_cnt == TICK_DIV - 1);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Waits for PTT to fall, counting the ticks sampled in the settle phase (R3).
    task automatic measure_key(input string req, input int cor_flip_at);
        int ticks = 0;
        bit keyed = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (i == cor_flip_at) cor_i = ~cor_i;
            if (!ptt_n_o) begin
                keyed = 1;
                break;
            end
            if (inhibit_o && ms_tick_i) ticks++;
        end
        check(keyed, {req, " ptt fell"}, keyed, 1);
        check(ticks == SETTLE_MS, {req, " settle ticks"}, ticks, SETTLE_MS);
        check(inhibit_o == 1'b1, {req, " inhibit at key"}, inhibit_o, 1);
    endtask

    // Ends an inhibited transmission and checks the exit order (R6).
    task automatic release_inhibited();
        bit last_tick;
        @(negedge clk);
        id_req_i = 1'b0;
        repeat (3) @(negedge clk);
        check(ptt_n_o == 1'b1, "R6 ptt released", ptt_n_o, 1);
        check(inhibit_o == 1'b1, "R6 inhibit held", inhibit_o, 1);
        last_tick = ms_tick_i;
        for (int i = 0; i < 4 * TICK_DIV; i++) begin
            @(negedge clk);
            if (!inhibit_o) break;
            last_tick = ms_tick_i;
        end
        check(!inhibit_o && last_tick, "R6 inhibit drops on tick", last_tick, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(ptt_n_o == 1'b1, "R1 ptt_n in reset", ptt_n_o, 1);
        check(inhibit_o == 1'b0, "R1 inhibit in reset", inhibit_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ptt_n_o && !inhibit_o, "R1 idle after reset", ptt_n_o, 1);
    endtask

    task automatic t_idle_link();
        cor_i = 1'b0;
        @(negedge clk);
        id_req_i = 1'b1;
        repeat (2) @(negedge clk);
        check(inhibit_o == 1'b0, "R2 inhibit not yet", inhibit_o, 0);
        @(negedge clk);
        check(inhibit_o == 1'b1, "R2 inhibit on 3rd edge", inhibit_o, 1);
        check(ptt_n_o == 1'b1, "R2 ptt still off", ptt_n_o, 1);
        measure_key("R3 idle link", -1);
        release_inhibited();
    endtask

    task automatic t_busy_link();
        bit inh_seen = 0;
        cor_i = 1'b1;
        repeat (4) @(negedge clk);
        id_req_i = 1'b1;
        repeat (3) @(negedge clk);
        check(ptt_n_o == 1'b0, "R4 immediate key", ptt_n_o, 0);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (i == 50) cor_i = 1'b0;
            if (inhibit_o) inh_seen = 1;
        end
        check(!inh_seen, "R4 no inhibit while plain keyed", inh_seen, 0);
        id_req_i = 1'b0;
        repeat (3) @(negedge clk);
        check(ptt_n_o && !inhibit_o, "R4 plain release", ptt_n_o, 1);
        repeat (5) @(negedge clk);
    endtask

    task automatic t_cor_latched();
        bit inh_low = 0;
        cor_i = 1'b0;
        repeat (4) @(negedge clk);
        id_req_i = 1'b1;
        measure_key("R5 cor rises in settle", 200);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (i % 15 == 0) cor_i = ~cor_i;
            if (!inhibit_o || ptt_n_o) inh_low = 1;
        end
        check(!inh_low, "R5 cor toggles while keyed", inh_low, 0);
        cor_i = 1'b0;
        release_inhibited();
    endtask

    task automatic t_abort_settle();
        bit keyed = 0;
        cor_i = 1'b0;
        repeat (4) @(negedge clk);
        id_req_i = 1'b1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!ptt_n_o) keyed = 1;
        end
        id_req_i = 1'b0;
        repeat (3) @(negedge clk);
        check(inhibit_o == 1'b0, "R7 inhibit drops on abort", inhibit_o, 0);
        check(!keyed && ptt_n_o, "R7 never keyed", keyed, 0);
        repeat (10) @(negedge clk);
        id_req_i = 1'b1;
        measure_key("R7 full delay after abort", -1);
        release_inhibited();
    endtask

    task automatic t_rerequest_release();
        cor_i = 1'b0;
        repeat (4) @(negedge clk);
        id_req_i = 1'b1;
        measure_key("R8 first key", -1);
        while (!ms_tick_i) @(negedge clk);
        @(negedge clk);
        id_req_i = 1'b0;
        repeat (3) @(negedge clk);
        check(ptt_n_o && inhibit_o, "R8 in release wait", inhibit_o, 1);
        id_req_i = 1'b1;
        measure_key("R8 restart from release", -1);
        release_inhibited();
    endtask

    initial begin
        t_reset();
        t_idle_link();
        t_busy_link();
        t_cor_latched();
        t_abort_settle();
        t_rerequest_release();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule